// File: doc/BRIEF.md
# Oldest-First Squash Request Arbiter

This block sits at the execute stage of one hardware thread in an out-of-order core. In each cycle, a fixed number of execute slots report their results. Any slot may carry a resolved branch that was mispredicted. A slot that holds a memory instruction may also be where the memory-ordering checker hands over a pending violation. The arbiter walks the slots from slot 0 upward and keeps one candidate squash. The candidate is the oldest redirect it has seen, measured by sequence number. The arbiter then registers that candidate as the single squash message sent to the commit side.

The two redirect sources differ in three ways:
- **Branch squash.** It points fetch at the instruction after the branch, which is supplied as an input. It spares the branch itself and carries the branch's taken bit.
- **Ordering-violation squash.** It points fetch back at the violator's own PC and includes the violator in the flush.
- **Age ties.** A branch must be strictly older to displace a held candidate, while a violator also wins a tie.

Once a redirect is held, a slot is only examined if it is older than the held squash. A violation that reaches a slot that is not examined is consumed and reported as dropped, without being acted on. The arbiter keeps no state from one cycle to the next, so the message is rebuilt from scratch every cycle.

Top module: `squash_arbiter`

## Requirements
- R1: While reset is asserted and after its release with no request, every output is 0.
- R2: The squash message appears on the outputs in the cycle after the slots report. A cycle with no acted-on request yields `sq_valid`=0 with seq, pc, include, taken and dropped all 0, whatever the previous cycle produced.
- R3: An acted-on branch mispredict produces `sq_seq` equal to the slot sequence number, `sq_pc` equal to the slot next-PC, `sq_incl`=0, and `sq_taken` equal to the slot taken bit.
- R4: An acted-on ordering violation produces `sq_seq`=`vio_seq`, `sq_pc`=`vio_pc`, `sq_incl`=1 and `sq_taken`=0.
- R5: When several slots mispredict in one cycle, the smallest sequence number wins, whichever slot carries it. A slot whose sequence number is not smaller than the held squash's is not examined.
- R6: A violation whose violator sequence number equals or is below the held branch squash replaces that squash.
- R7: A branch whose sequence number equals the held violation squash does not replace it. A branch with a strictly smaller sequence number does replace it.
- R8: A mispredict reported on a load slot whose `ex_done` bit is 0 is ignored. The same mispredict with `ex_done`=1 is acted on.
- R9: A pending violation is taken up only by the lowest-numbered valid slot with `ex_mem`=1 that has no acted-on mispredict. If that slot is not examined (see R5), `vio_dropped`=1 and the held squash is unchanged. A violation that meets no memory slot has no effect.
- R10: A slot with `ex_valid`=0 has no effect, whatever its other fields hold.
- R11: A violation whose violator sequence number is greater than the held squash's neither replaces it nor sets `vio_dropped`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | LANES | Slot holds an instruction (bit i = slot i; slot 0 examined first) |
| ex_mem | input | LANES | Slot is a memory reference |
| ex_load | input | LANES | Slot is a load |
| ex_done | input | LANES | Slot instruction has executed |
| ex_mispred | input | LANES | Slot is a mispredicted branch |
| ex_taken | input | LANES | Branch taken bit of the slot |
| ex_seq | input | LANES*SEQ_W | Slot sequence numbers, slot i at [i*SEQ_W +: SEQ_W] |
| ex_npc | input | LANES*PC_W | PC after each slot instruction, slot i at [i*PC_W +: PC_W] |
| vio_valid | input | 1 | Ordering violation pending this cycle |
| vio_seq | input | SEQ_W | Violator sequence number |
| vio_pc | input | PC_W | Violator PC |
| sq_valid | output | 1 | Squash requested |
| sq_seq | output | SEQ_W | Sequence number at which the squash starts |
| sq_pc | output | PC_W | Redirect PC |
| sq_incl | output | 1 | Squash includes the instruction at `sq_seq` |
| sq_taken | output | 1 | Taken bit of the squashing branch |
| vio_dropped | output | 1 | A violation was seen but not acted on |

## Verification
The bench targets the age-tie cases in both directions. A design that used the same comparison for both sources would let an equal-age branch overwrite a violation, or would keep a branch that a tying violator should replace. Slot order is swapped so that the older mispredict arrives in either slot. A design that simply kept the first or last redirect would report the wrong sequence number and PC. Further cases cover:
- an unexecuted load mispredict, which a careless design would turn into a spurious squash;
- a violation arriving behind an older branch, which must be dropped, not acted on and not silently lost;
- an idle cycle after a squash, which exposes any candidate carried over from the previous cycle.

// File: rtl/sqarb_pkg.sv
package sqarb_pkg;

  localparam int DEF_SEQ_W = 16;
  localparam int DEF_PC_W  = 32;

  // Control flags carried along the slot chain.
  typedef struct packed {
    logic pend;      // a candidate squash is held
    logic redir;     // a redirect was acted on this cycle
    logic vio_live;  // violation not yet consumed by a memory slot
    logic dropped;   // violation consumed without effect
    logic incl;      // candidate includes its own instruction
    logic taken;     // candidate branch taken bit
  } chain_flags_t;

endpackage

// File: rtl/sqarb_slot.sv
module sqarb_slot
  import sqarb_pkg::*;
#(
  parameter int SEQ_W = DEF_SEQ_W,
  parameter int PC_W  = DEF_PC_W
) (
  input  chain_flags_t     fl_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             valid,
  input  logic             mem,
  input  logic             load,
  input  logic             done,
  input  logic             mispred,
  input  logic             taken,
  input  logic [SEQ_W-1:0] slot_seq,
  input  logic [PC_W-1:0]  slot_npc,
  input  logic [SEQ_W-1:0] vio_seq,
  input  logic [PC_W-1:0]  vio_pc,
  output chain_flags_t     fl_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [PC_W-1:0]  pc_o
);

  logic examine;
  logic br_hit;
  logic vio_hit;

  // Slot is examined unless an older redirect is already held.
  assign examine = !fl_i.redir || !fl_i.pend || (seq_i > slot_seq);
  assign br_hit  = mispred && !(load && !done);
  assign vio_hit = fl_i.vio_live && mem;

  always_comb begin
    fl_o  = fl_i;
    seq_o = seq_i;
    pc_o  = pc_i;
    if (valid) begin
      if (examine) begin
        if (br_hit) begin
          fl_o.redir = 1'b1;
          if (!fl_i.pend || (slot_seq < seq_i)) begin
            fl_o.pend  = 1'b1;
            fl_o.incl  = 1'b0;
            fl_o.taken = taken;
            seq_o      = slot_seq;
            pc_o       = slot_npc;
          end
        end else if (vio_hit) begin
          fl_o.redir    = 1'b1;
          fl_o.vio_live = 1'b0;
          if (!fl_i.pend || (vio_seq <= seq_i)) begin
            fl_o.pend  = 1'b1;
            fl_o.incl  = 1'b1;
            fl_o.taken = 1'b0;
            seq_o      = vio_seq;
            pc_o       = vio_pc;
          end
        end
      end else if (vio_hit) begin
        fl_o.vio_live = 1'b0;
        fl_o.dropped  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sqarb_hold.sv
module sqarb_hold
  import sqarb_pkg::*;
#(
  parameter int SEQ_W = DEF_SEQ_W,
  parameter int PC_W  = DEF_PC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  chain_flags_t     fl_d,
  input  logic [SEQ_W-1:0] seq_d,
  input  logic [PC_W-1:0]  pc_d,
  output logic             sq_valid,
  output logic [SEQ_W-1:0] sq_seq,
  output logic [PC_W-1:0]  sq_pc,
  output logic             sq_incl,
  output logic             sq_taken,
  output logic             vio_dropped
);

  logic             valid_n, incl_n, taken_n, drop_n;
  logic [SEQ_W-1:0] seq_n;
  logic [PC_W-1:0]  pc_n;

  // Next state: fields are zeroed when no squash is held.
  always_comb begin
    valid_n = fl_d.pend;
    incl_n  = fl_d.pend & fl_d.incl;
    taken_n = fl_d.pend & fl_d.taken;
    seq_n   = fl_d.pend ? seq_d : '0;
    pc_n    = fl_d.pend ? pc_d  : '0;
    drop_n  = fl_d.dropped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_valid    <= 1'b0;
      sq_seq      <= '0;
      sq_pc       <= '0;
      sq_incl     <= 1'b0;
      sq_taken    <= 1'b0;
      vio_dropped <= 1'b0;
    end else if (ld_en) begin
      sq_valid    <= valid_n;
      sq_seq      <= seq_n;
      sq_pc       <= pc_n;
      sq_incl     <= incl_n;
      sq_taken    <= taken_n;
      vio_dropped <= drop_n;
    end
  end

endmodule

// File: rtl/squash_arbiter.sv
module squash_arbiter
  import sqarb_pkg::*;
#(
  parameter int LANES = 2,
  parameter int SEQ_W = DEF_SEQ_W,
  parameter int PC_W  = DEF_PC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       ex_valid,
  input  logic [LANES-1:0]       ex_mem,
  input  logic [LANES-1:0]       ex_load,
  input  logic [LANES-1:0]       ex_done,
  input  logic [LANES-1:0]       ex_mispred,
  input  logic [LANES-1:0]       ex_taken,
  input  logic [LANES*SEQ_W-1:0] ex_seq,
  input  logic [LANES*PC_W-1:0]  ex_npc,
  input  logic                   vio_valid,
  input  logic [SEQ_W-1:0]       vio_seq,
  input  logic [PC_W-1:0]        vio_pc,
  output logic                   sq_valid,
  output logic [SEQ_W-1:0]       sq_seq,
  output logic [PC_W-1:0]        sq_pc,
  output logic                   sq_incl,
  output logic                   sq_taken,
  output logic                   vio_dropped
);

  localparam int STAGES = LANES + 1;

  chain_flags_t     fl  [STAGES];
  logic [SEQ_W-1:0] cseq[STAGES];
  logic [PC_W-1:0]  cpc [STAGES];

  // Chain head: nothing held, redirect tracking cleared for this cycle.
  always_comb begin
    fl[0]          = '0;
    fl[0].vio_live = vio_valid;
    cseq[0]        = '0;
    cpc[0]         = '0;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_slot
    sqarb_slot #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_slot (
      .fl_i     (fl[i]),
      .seq_i    (cseq[i]),
      .pc_i     (cpc[i]),
      .valid    (ex_valid[i]),
      .mem      (ex_mem[i]),
      .load     (ex_load[i]),
      .done     (ex_done[i]),
      .mispred  (ex_mispred[i]),
      .taken    (ex_taken[i]),
      .slot_seq (ex_seq[i*SEQ_W +: SEQ_W]),
      .slot_npc (ex_npc[i*PC_W +: PC_W]),
      .vio_seq  (vio_seq),
      .vio_pc   (vio_pc),
      .fl_o     (fl[i+1]),
      .seq_o    (cseq[i+1]),
      .pc_o     (cpc[i+1])
    );
  end

  sqarb_hold #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_en       (1'b1),
    .fl_d        (fl[LANES]),
    .seq_d       (cseq[LANES]),
    .pc_d        (cpc[LANES]),
    .sq_valid    (sq_valid),
    .sq_seq      (sq_seq),
    .sq_pc       (sq_pc),
    .sq_incl     (sq_incl),
    .sq_taken    (sq_taken),
    .vio_dropped (vio_dropped)
  );

endmodule

// File: rtl/sqarb_chk.sv
module sqarb_chk #(
  parameter int LANES = 2,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] ex_valid,
  input logic [LANES-1:0] ex_mispred,
  input logic             sq_valid,
  input logic             sq_incl,
  input logic             sq_taken,
  input logic             vio_dropped
);

  // R2
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid == '0) |=> (!sq_valid && !vio_dropped));

  // R3
  no_branch_no_br_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ex_valid & ex_mispred) == '0) |=> !(sq_valid && !sq_incl));

  // R4
  incl_taken_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_incl |-> (sq_valid && !sq_taken));

  // R9
  drop_needs_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vio_dropped |-> sq_valid);

  // R2
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_valid |-> (!sq_incl && !sq_taken));

endmodule

bind squash_arbiter sqarb_chk #(.LANES(LANES), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ex_valid    (ex_valid),
  .ex_mispred  (ex_mispred),
  .sq_valid    (sq_valid),
  .sq_incl     (sq_incl),
  .sq_taken    (sq_taken),
  .vio_dropped (vio_dropped)
);

// File: tb/sim_squash_arbiter.sv
`timescale 1ns/1ps
module sim_squash_arbiter;

  localparam int L  = 2;
  localparam int SW = 16;
  localparam int PW = 32;

  typedef struct {
    logic          v;
    logic [SW-1:0] s;
    logic [PW-1:0] p;
    logic          i;
    logic          t;
    logic          d;
    string         tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [L-1:0]    ex_valid, ex_mem, ex_load, ex_done, ex_mispred, ex_taken;
  logic [L*SW-1:0] ex_seq;
  logic [L*PW-1:0] ex_npc;
  logic            vio_valid;
  logic [SW-1:0]   vio_seq;
  logic [PW-1:0]   vio_pc;
  logic            sq_valid, sq_incl, sq_taken, vio_dropped;
  logic [SW-1:0]   sq_seq;
  logic [PW-1:0]   sq_pc;

  int   tests = 0;
  int   fails = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  squash_arbiter #(.LANES(L), .SEQ_W(SW), .PC_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ex_valid(ex_valid), .ex_mem(ex_mem), .ex_load(ex_load), .ex_done(ex_done),
    .ex_mispred(ex_mispred), .ex_taken(ex_taken), .ex_seq(ex_seq), .ex_npc(ex_npc),
    .vio_valid(vio_valid), .vio_seq(vio_seq), .vio_pc(vio_pc),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_pc(sq_pc), .sq_incl(sq_incl),
    .sq_taken(sq_taken), .vio_dropped(vio_dropped)
  );

  task automatic compare(input exp_t e);
    tests++;
    if (sq_valid !== e.v || sq_seq !== e.s || sq_pc !== e.p ||
        sq_incl !== e.i || sq_taken !== e.t || vio_dropped !== e.d) begin
      fails++;
      $display("FAIL %s: got v=%0b seq=%0d pc=%h incl=%0b tk=%0b drop=%0b exp v=%0b seq=%0d pc=%h incl=%0b tk=%0b drop=%0b",
               e.tag, sq_valid, sq_seq, sq_pc, sq_incl, sq_taken, vio_dropped,
               e.v, e.s, e.p, e.i, e.t, e.d);
    end
  endtask

  task automatic drive(input logic [L-1:0] v, mem, ld, dn, mp, tk,
                       input logic [SW-1:0] s0, s1,
                       input logic [PW-1:0] n0, n1,
                       input logic vv, input logic [SW-1:0] vs, input logic [PW-1:0] vp,
                       input logic ev, input logic [SW-1:0] es, input logic [PW-1:0] ep,
                       input logic ei, et, ed, input string tag);
    exp_t e;
    @(negedge clk);
    ex_valid = v; ex_mem = mem; ex_load = ld; ex_done = dn;
    ex_mispred = mp; ex_taken = tk;
    ex_seq = {s1, s0}; ex_npc = {n1, n0};
    vio_valid = vv; vio_seq = vs; vio_pc = vp;
    e.v = ev; e.s = es; e.p = ep; e.i = ei; e.t = et; e.d = ed; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: one expected item per clock, sampled after the edge settles.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 5000) begin
        tests++; fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    exp_t r;
    rst_n = 1'b0;
    ex_valid = '0; ex_mem = '0; ex_load = '0; ex_done = '0;
    ex_mispred = '0; ex_taken = '0; ex_seq = '0; ex_npc = '0;
    vio_valid = 1'b0; vio_seq = '0; vio_pc = '0;
    repeat (3) @(posedge clk);
    #2;
    r.v = 0; r.s = 0; r.p = 0; r.i = 0; r.t = 0; r.d = 0; r.tag = "R1 in reset";
    compare(r);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    r.tag = "R1 after release";
    compare(r);

    // R3 single branch
    drive(2'b01, 2'b00, 2'b00, 2'b01, 2'b01, 2'b01, 16'd10, 16'd0, 32'h104, 32'h0,
          0, 0, 0, 1, 16'd10, 32'h104, 0, 1, 0, "R3 branch");
    // R2 idle after squash
    drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0,
          0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 idle clears");
    // R4 violation
    drive(2'b01, 2'b01, 2'b00, 2'b01, 2'b00, 2'b00, 16'd20, 16'd0, 32'h0, 32'h0,
          1, 16'd18, 32'h200, 1, 16'd18, 32'h200, 1, 0, 0, "R4 violation");
    // R5 older in slot 1
    drive(2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 2'b10, 16'd30, 16'd25, 32'hA0, 32'hB0,
          0, 0, 0, 1, 16'd25, 32'hB0, 0, 1, 0, "R5 older slot1");
    // R5 older in slot 0
    drive(2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 2'b10, 16'd25, 16'd30, 32'hA0, 32'hB0,
          0, 0, 0, 1, 16'd25, 32'hA0, 0, 0, 0, "R5 older slot0");
    // R6 violator ties held branch
    drive(2'b11, 2'b10, 2'b00, 2'b11, 2'b01, 2'b01, 16'd5, 16'd4, 32'h50, 32'h0,
          1, 16'd5, 32'h40, 1, 16'd5, 32'h40, 1, 0, 0, "R6 tie to violation");
    // R7 branch equal to held violation does not replace
    drive(2'b11, 2'b01, 2'b00, 2'b11, 2'b10, 2'b10, 16'd2, 16'd5, 32'h0, 32'h60,
          1, 16'd5, 32'h44, 1, 16'd5, 32'h44, 1, 0, 0, "R7 equal branch kept out");
    // R7 strictly older branch replaces
    drive(2'b11, 2'b01, 2'b00, 2'b11, 2'b10, 2'b10, 16'd2, 16'd4, 32'h0, 32'h64,
          1, 16'd5, 32'h44, 1, 16'd4, 32'h64, 0, 1, 0, "R7 older branch wins");
    // R8 unexecuted load mispredict ignored
    drive(2'b01, 2'b01, 2'b01, 2'b00, 2'b01, 2'b00, 16'd7, 16'd0, 32'h70, 32'h0,
          0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 load not done");
    // R8 executed load mispredict acted on
    drive(2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b00, 16'd7, 16'd0, 32'h70, 32'h0,
          0, 0, 0, 1, 16'd7, 32'h70, 0, 0, 0, "R8 load done");
    // R9 violation behind older branch dropped
    drive(2'b11, 2'b10, 2'b00, 2'b11, 2'b01, 2'b00, 16'd3, 16'd8, 32'h30, 32'h0,
          1, 16'd8, 32'h80, 1, 16'd3, 32'h30, 0, 0, 1, "R9 dropped");
    // R9 violation with no memory slot has no effect
    drive(2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 16'd6, 16'd0, 32'h0, 32'h0,
          1, 16'd6, 32'h90, 0, 0, 0, 0, 0, 0, "R9 no mem slot");
    // R10 invalid slots ignored
    drive(2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 16'd1, 16'd2, 32'h10, 32'h20,
          1, 16'd1, 32'h11, 0, 0, 0, 0, 0, 0, "R10 invalid slots");
    // R11 younger violator does not replace, not dropped
    drive(2'b11, 2'b10, 2'b00, 2'b11, 2'b01, 2'b00, 16'd3, 16'd2, 32'h30, 32'h0,
          1, 16'd9, 32'h99, 1, 16'd3, 32'h30, 0, 0, 0, "R11 younger violator");
    // R2 final idle
    drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0,
          0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 final idle");

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule